// File: doc/BRIEF.md
# Configurable Infrared Carrier Generator

This block produces an infrared-remote style carrier on a single output pin. Its time base is the instruction clock, one tick for every four system clocks. A static configuration sets the carrier period to m×2^n instruction ticks, with m of 2 or 3 and n from 0 to 3. The same configuration sets the active-low duty of the waveform, and a pin-mode setting picks whether the pin carries the carrier or a plain level.

A single data bit, written and read over a simple bus, controls the pin. In carrier mode a 0 in the bit runs the carrier and a 1 parks the pin high. In level mode the pin drives the bit directly. Reads always return the stored bit rather than the pin, so software can do read-modify-write safely while the carrier toggles. The divider is built from a prescaler, a ÷2/÷3 prime stage and a 3-bit binary counter, and it restarts from a known phase every time the carrier is switched on.

Top module: `irc_carrier_gen`

## Requirements
- R1: After reset the data bit is 1, `rdData` is 1 and `pinOut` is 1 in both pin modes.
- R2: A cycle with `wrEn`=1 stores `wrData` in the data bit at that clock edge. `rdData` always returns the stored bit, even while the pin is low.
- R3: With `cfgCarrierMode`=0 (level mode), `pinOut` equals the data bit.
- R4: With `cfgCarrierMode`=1 and the data bit at 1, `pinOut` is 1. A write of 1 forces the pin high from the same clock edge, even in the middle of a low phase.
- R5: Suppose a write of 0 in carrier mode takes effect at edge E0. `pinOut` stays 1 after edges E0 to E3 and goes low after edge E4, which is the first instruction tick.
- R6: The carrier period is 4·m·2^n system clocks. `cfgM3`=1 selects m=3 and `cfgM3`=0 selects m=2. `cfgN` (2 bits) gives n.
- R7: With m=2 the pin is low for the first half of each period, which is (2^n) instruction ticks.
- R8: With m=3 and n=0 the pin is low for 1 tick and high for 2 ticks, whatever `cfgThird` holds.
- R9: With m=3 and n from 1 to 3, `cfgThird`=1 gives 2^n low ticks out of 3·2^n. `cfgThird`=0 gives 3·2^(n-1) low ticks.
- R10: A disable followed by a re-enable restarts the divider, so the timing of R5 applies again from the new enabling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgCarrierMode | input | 1 | 1 = carrier on pin, 0 = level on pin |
| cfgM3 | input | 1 | 1 selects the ÷3 prime stage, 0 selects ÷2 |
| cfgN | input | 2 | Binary exponent n of the divide ratio |
| cfgThird | input | 1 | Selects 1/3 low duty for m=3, n≥1 |
| wrEn | input | 1 | Write strobe for the data bit |
| wrData | input | 1 | Value written to the data bit |
| rdData | output | 1 | Stored data bit (read path) |
| pinOut | output | 1 | Pin level |

## Verification
The hardest situation to reach is a disable that lands in the middle of a low phase, followed by a re-enable. The pin must rise at once, and the prescaler and divider must start again from phase zero instead of carrying on. The bench runs a carrier, waits until it has sampled the pin low, then writes 1 and checks the pin on the next sample. It then re-enables and replays the full start-up and period pattern of R5 to R9, with each expected sample computed from the sample's distance to the enabling edge. A sweep over all sixteen combinations of m, n and duty select covers every ratio and duty.

// File: rtl/irc_pkg.sv
package irc_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clear;   // hold divider at idle phase
    logic tick;    // one instruction-clock tick
  } ircStrobe_t;
endpackage

// File: rtl/irc_ctrl.sv
module irc_ctrl
  import irc_pkg::*;
#(
  parameter int PRE_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgCarrierMode,
  input  logic       wrEn,
  input  logic       wrData,
  output logic       dataBit,
  output logic       carrierOn,
  output ircStrobe_t strobe
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0] preCnt;

  // Port data register, idles high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataBit <= 1'b1;
    else if (wrEn) dataBit <= wrData;
  end

  assign carrierOn = cfgCarrierMode & ~dataBit;

  // Instruction-clock prescaler, held at zero while the carrier is off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else if (!carrierOn) preCnt <= '0;
    else if (preCnt == PRE_LAST) preCnt <= '0;
    else preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    strobe.clear = ~carrierOn;
    strobe.tick  = carrierOn & (preCnt == PRE_LAST);
  end
endmodule

// File: rtl/irc_dp.sv
module irc_dp
  import irc_pkg::*;
#(
  parameter int N_W   = 2,
  parameter int BIN_W = 3
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cfgM3,
  input  logic [N_W-1:0] cfgN,
  input  logic           cfgThird,
  input  ircStrobe_t     strobe,
  output logic           lowPhase
);
  localparam int POS_W = BIN_W + 2;

  logic             started;
  logic [1:0]       primeCnt;
  logic [BIN_W-1:0] binCnt;
  logic [1:0]       primeLast;
  logic [BIN_W-1:0] binLast;
  logic [BIN_W:0]   binSpan;
  logic [POS_W-1:0] posVal;
  logic [POS_W-1:0] periodLen;
  logic [POS_W-1:0] lowLen;
  logic [POS_W-1:0] mVal;

  always_comb begin
    mVal      = cfgM3 ? POS_W'(3) : POS_W'(2);
    primeLast = cfgM3 ? 2'd2 : 2'd1;
    binSpan   = (BIN_W+1)'(1) << cfgN;
    binLast   = BIN_W'(binSpan - 1'b1);
    periodLen = mVal << cfgN;
    if (cfgM3 && (cfgThird || cfgN == '0)) lowLen = POS_W'(binSpan);
    else lowLen = periodLen >> 1;
    posVal = POS_W'(binCnt) * mVal + POS_W'(primeCnt);
  end

  // Prime stage (mod m) feeding a binary stage (mod 2^n)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      started  <= 1'b0;
      primeCnt <= '0;
      binCnt   <= '0;
    end else if (strobe.clear) begin
      started  <= 1'b0;
      primeCnt <= '0;
      binCnt   <= '0;
    end else if (strobe.tick) begin
      if (!started) begin
        started  <= 1'b1;
        primeCnt <= '0;
        binCnt   <= '0;
      end else if (primeCnt == primeLast) begin
        primeCnt <= '0;
        binCnt   <= (binCnt == binLast) ? '0 : binCnt + 1'b1;
      end else begin
        primeCnt <= primeCnt + 1'b1;
      end
    end
  end

  assign lowPhase = started & (posVal < lowLen);
endmodule

// File: rtl/irc_carrier_gen.sv
module irc_carrier_gen
  import irc_pkg::*;
#(
  parameter int PRE_DIV = 4,
  parameter int N_W     = 2,
  parameter int BIN_W   = 3
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cfgCarrierMode,
  input  logic           cfgM3,
  input  logic [N_W-1:0] cfgN,
  input  logic           cfgThird,
  input  logic           wrEn,
  input  logic           wrData,
  output logic           rdData,
  output logic           pinOut
);
  ircStrobe_t strobe;
  logic       dataBit;
  logic       carrierOn;
  logic       lowPhase;

  irc_ctrl #(.PRE_DIV(PRE_DIV)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgCarrierMode(cfgCarrierMode),
    .wrEn(wrEn), .wrData(wrData), .dataBit(dataBit),
    .carrierOn(carrierOn), .strobe(strobe)
  );

  irc_dp #(.N_W(N_W), .BIN_W(BIN_W)) dp_i (
    .clk(clk), .rstN(rstN), .cfgM3(cfgM3), .cfgN(cfgN),
    .cfgThird(cfgThird), .strobe(strobe), .lowPhase(lowPhase)
  );

  assign rdData = dataBit;
  assign pinOut = cfgCarrierMode ? ~(carrierOn & lowPhase) : dataBit;
endmodule

// File: rtl/irc_chk.sv
module irc_chk (
  input logic clk,
  input logic rstN,
  input logic cfgCarrierMode,
  input logic wrEn,
  input logic wrData,
  input logic rdData,
  input logic pinOut
);
  // R2
  wr_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (rdData == $past(wrData)));
  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(rdData));
  // R3
  level_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgCarrierMode |-> (pinOut == rdData));
  // R4
  parked_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgCarrierMode && rdData) |-> pinOut);
  // R5
  start_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgCarrierMode && $fell(rdData)) |-> pinOut);
endmodule

bind irc_carrier_gen irc_chk chk_i (
  .clk(clk), .rstN(rstN), .cfgCarrierMode(cfgCarrierMode),
  .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .pinOut(pinOut)
);

// File: tb/irc_carrier_gen_tb_top.sv
module irc_carrier_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgCarrierMode = 1'b1;
  logic       cfgM3 = 1'b0;
  logic [1:0] cfgN = 2'd0;
  logic       cfgThird = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrData = 1'b0;
  logic       rdData;
  logic       pinOut;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irc_carrier_gen dut_i (
    .clk(clk), .rstN(rstN), .cfgCarrierMode(cfgCarrierMode),
    .cfgM3(cfgM3), .cfgN(cfgN), .cfgThird(cfgThird),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .pinOut(pinOut)
  );

  task automatic check(input string req, input logic act, input logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0b expected %0b (m3=%0b n=%0d third=%0b)",
               req, act, exp, cfgM3, cfgN, cfgThird);
    end
  endtask

  // Write at the next edge; returns at the negedge right after it
  task automatic doWrite(input logic v);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic expPin(input int j, input int p, input int lowT);
    if (j < 4) return 1'b1;
    return (((j - 4) / 4) % p < lowT) ? 1'b0 : 1'b1;
  endfunction

  // Enable, then check 'span' samples; j = edges since the enabling edge
  task automatic runCarrier(input int span, input string tagStart);
    int m;
    int p;
    int lowT;
    string tag;
    m = cfgM3 ? 3 : 2;
    p = m * (1 << cfgN);
    if (!cfgM3) begin lowT = p / 2; tag = "R7"; end
    else if (cfgN == 0) begin lowT = 1; tag = "R8"; end
    else if (cfgThird) begin lowT = 1 << cfgN; tag = "R9"; end
    else begin lowT = p / 2; tag = "R9"; end
    doWrite(1'b0);
    for (int j = 0; j < span; j++) begin
      if (j > 0) @(negedge clk);
      if (j < 4) check(tagStart, pinOut, 1'b1);
      else if (j >= 4 + 4 * p) check("R6", pinOut, expPin(j, p, lowT));
      else check(tag, pinOut, expPin(j, p, lowT));
    end
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        testsFailed++;
        $display("FAIL watchdog: actual %0d expected below %0d", cycles, WATCHDOG);
        $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", rdData, 1'b1);
    check("R1", pinOut, 1'b1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", pinOut, 1'b1);

    // R3 level mode follows the data bit
    cfgCarrierMode = 1'b0;
    @(negedge clk);
    check("R3", pinOut, 1'b1);
    doWrite(1'b0);
    check("R3", pinOut, 1'b0);
    check("R2", rdData, 1'b0);
    repeat (10) @(negedge clk);
    check("R3", pinOut, 1'b0);
    doWrite(1'b1);
    check("R3", pinOut, 1'b1);
    cfgCarrierMode = 1'b1;
    @(negedge clk);
    check("R4", pinOut, 1'b1);

    // R2 read returns register while pin is low; R4 mid-low disable
    cfgM3 = 1'b0; cfgN = 2'd3; cfgThird = 1'b0;
    runCarrier(8, "R5");
    check("R2", pinOut, 1'b0);
    check("R2", rdData, 1'b0);
    doWrite(1'b1);
    check("R4", pinOut, 1'b1);
    check("R2", rdData, 1'b1);
    repeat (20) @(negedge clk);
    check("R4", pinOut, 1'b1);

    // R10 re-enable restarts from phase zero
    runCarrier(4 + 4 * 16 * 2, "R10");
    doWrite(1'b1);

    // Full sweep: R5..R9 over every ratio and duty select
    for (int c = 0; c < 16; c++) begin
      cfgM3 = c[3];
      cfgN = c[2:1];
      cfgThird = c[0];
      @(negedge clk);
      runCarrier(4 + 4 * (cfgM3 ? 3 : 2) * (1 << cfgN) * 2, "R5");
      doWrite(1'b1);
      check("R4", pinOut, 1'b1);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule